// File: doc/BRIEF.md
# Debug Hart Handshake Mailbox

This block is a memory-mapped slave that sits on the load/store path a halted core uses while it spins in its debug loop. Each hart owns one flag byte whose two bits say "run the abstract command" (GO) and "leave debug mode" (RESUME). The command generator sets those bits through pulse inputs. The hart polls its byte and reports progress by storing its own hart number to one of four mailbox words. These stores update the per-hart halted and resume-acknowledge status, the abstract-command busy bit and the command error field.

The slave also returns a read-only jump word. That word is a JAL x0 that lands on a two-word abstract-instruction buffer. The contents of that buffer come in on input ports from the command generator. Every access gets a registered response one cycle after it is presented, with an error flag for anything the map does not allow.

Top module: `dbg_hart_mailbox`

## Requirements
- R1: After reset, all GO and RESUME flags, all halted and resumeack bits, and busy are 0, and cmderr is 0 (none).
- R2: A `go_cmd` pulse sets bit 0 (GO) of the selected hart's flag byte and sets busy. A `resume_cmd` pulse sets bit 1 (RESUME) of that byte and clears resumeack of the selected hart. A set takes priority over a same-cycle clear of the same flag.
- R3: A store of any size to the GOING word at 0x104 clears the GO bit of the currently selected hart.
- R4: A 4-byte store (size code 2) of value id to the HALTED word at 0x100 sets halted[id]. It clears busy only when id equals the selected hart and that hart's GO bit is 0. A `go_cmd` in the same cycle keeps busy set.
- R5: A 4-byte store of value id to the RESUMING word at 0x108 clears halted[id], sets resumeack[id] and clears RESUME of hart id.
- R6: A store to the EXCEPTION word at 0x10C sets cmderr to 3 only when cmderr is 0. Any non-zero cmderr is kept.
- R7: A read at 0x400 + n returns the four flag bytes of word-aligned offset n & ~3, little-endian, so byte lane k holds hart (n & ~3) + k. The flag region spans 0x400 to 0x7FF, and bytes for hart numbers at or above NUM_HARTS read 0.
- R8: A read of 0x300 returns 0x0380006F, which is JAL x0 with offset +0x38 to the abstract buffer at 0x338. Reads of 0x338 and 0x33C return `abs_word0` and `abs_word1`.
- R9: The following accesses get rsp_err and change no state:
  - any address outside the mailbox words, 0x300, 0x338 to 0x33F and the flag region;
  - reads of a mailbox word;
  - writes to the jump word, the buffer or the flags;
  - HALTED or RESUMING stores that are not 4 bytes or whose id is NUM_HARTS or more.
- R10: rsp_valid is high exactly one cycle after req_valid. rsp_rdata is 0 for writes and errors.
- R11: `err_clr` forces cmderr to 0 and wins over everything else. When cmderr is 0, `err_set` loads `err_code`, but an EXCEPTION store in the same cycle takes priority. When cmderr is non-zero, `err_set` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request from the hart |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_addr | input | 12 | Byte address in the debug window |
| req_wdata | input | 32 | Store data (hart number for mailboxes) |
| rsp_valid | output | 1 | Response, one cycle after request |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Load data |
| sel_hart | input | 4 | Hart selected by the debugger |
| go_cmd | input | 1 | Launch an abstract command on the selected hart |
| resume_cmd | input | 1 | Request resume of the selected hart |
| abs_word0 | input | 32 | Abstract buffer word 0 |
| abs_word1 | input | 32 | Abstract buffer word 1 |
| err_set | input | 1 | Command generator reports an error |
| err_code | input | 3 | Error code for err_set |
| err_clr | input | 1 | Clear cmderr |
| halted | output | 16 | Per-hart halted status |
| resumeack | output | 16 | Per-hart resume acknowledge |
| busy | output | 1 | Abstract command in progress |
| cmderr | output | 3 | Command error field |

## Verification
The bench builds the block with NUM_HARTS = 16. With that value the flag word at 0x40C holds the last four harts in its four lanes, and the word at 0x410 lies wholly beyond them, so both the top lane and the zero-fill past the last hart are reachable. It also makes a mailbox id of 20 an out-of-range value. The behavioural model replays halt, go and resume sequences, including a HALTED store while GO is still pending and one from an unselected hart, and it checks EXCEPTION stores both with cmderr clear and with an earlier error already latched.

// File: rtl/dbg_mbox_pkg.sv
// Shared address map, region codes and jump-word builder for the debug mailbox.
// Assumes a 12-bit byte address window and 32-bit data.
package dbg_mbox_pkg;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int ABS_WORDS  = 2;
    localparam int FLAG_BYTES = 1024;
    localparam int FLAG_GO_BIT  = 0;
    localparam int FLAG_RES_BIT = 1;

    localparam logic [ADDR_W-1:0] MB_HALTED   = 12'h100;
    localparam logic [ADDR_W-1:0] MB_GOING    = 12'h104;
    localparam logic [ADDR_W-1:0] MB_RESUMING = 12'h108;
    localparam logic [ADDR_W-1:0] MB_EXCEPT   = 12'h10C;
    localparam logic [ADDR_W-1:0] VEC_ADDR    = 12'h300;
    localparam logic [ADDR_W-1:0] ABS_BASE    = 12'h338;
    localparam logic [ADDR_W-1:0] ABS_END     = ABS_BASE + ADDR_W'(4 * ABS_WORDS);
    localparam logic [ADDR_W-1:0] FLAG_BASE   = 12'h400;
    localparam logic [ADDR_W-1:0] FLAG_END    = FLAG_BASE + ADDR_W'(FLAG_BYTES);

    localparam logic [1:0] SZ_WORD   = 2'd2;
    localparam logic [2:0] CE_NONE   = 3'd0;
    localparam logic [2:0] CE_EXCEPT = 3'd3;

    typedef enum logic [2:0] {
        RG_NONE, RG_HALTED, RG_GOING, RG_RESUMING,
        RG_EXCEPT, RG_VECTOR, RG_ABS, RG_FLAGS
    } region_e;

    // Build a JAL with rd = x0 from a byte offset.
    function automatic logic [31:0] jal_x0(input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'b1101111};
    endfunction

    localparam logic [31:0] VEC_WORD = jal_x0(21'(ABS_BASE - VEC_ADDR));
endpackage

// File: rtl/dbg_mbox_decode.sv
// Address decoder: maps a byte address to a region and flags accesses the
// map refuses (unmapped, loads of mailboxes, stores to read-only words).
// Assumes mailbox words are matched on the word address only.
module dbg_mbox_decode
    import dbg_mbox_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output region_e           region,
    output logic              deny
);
    // Region lookup.
    always_comb begin
        region = RG_NONE;
        if (addr[ADDR_W-1:2] == MB_HALTED[ADDR_W-1:2])        region = RG_HALTED;
        else if (addr[ADDR_W-1:2] == MB_GOING[ADDR_W-1:2])    region = RG_GOING;
        else if (addr[ADDR_W-1:2] == MB_RESUMING[ADDR_W-1:2]) region = RG_RESUMING;
        else if (addr[ADDR_W-1:2] == MB_EXCEPT[ADDR_W-1:2])   region = RG_EXCEPT;
        else if (addr[ADDR_W-1:2] == VEC_ADDR[ADDR_W-1:2])    region = RG_VECTOR;
        else if (addr >= ABS_BASE && addr < ABS_END)          region = RG_ABS;
        else if (addr >= FLAG_BASE && addr < FLAG_END)        region = RG_FLAGS;
    end

    // Direction check per region.
    always_comb begin
        case (region)
            RG_NONE:                                      deny = 1'b1;
            RG_HALTED, RG_GOING, RG_RESUMING, RG_EXCEPT:  deny = !write;
            default:                                      deny = write;
        endcase
    end
endmodule

// File: rtl/dbg_mbox_flags.sv
// Per-hart GO and RESUME flag flops. Sets come from the command generator for
// the selected hart; GO clears on the GOING mailbox (selected hart), RESUME
// clears on the RESUMING mailbox (hart named in the store). Set wins.
module dbg_mbox_flags #(
    parameter int NUM_HARTS = 16,
    parameter int HART_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HART_W-1:0]    sel,
    input  logic                 go_set,
    input  logic                 go_clr,
    input  logic                 res_set,
    input  logic                 res_clr,
    input  logic [HART_W-1:0]    res_clr_id,
    output logic [NUM_HARTS-1:0] go,
    output logic [NUM_HARTS-1:0] res
);
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic go_q, res_q;
        logic is_sel, is_rid;
        assign is_sel = (sel == HART_W'(h));
        assign is_rid = (res_clr_id == HART_W'(h));

        // GO flag of hart h.
        always_ff @(posedge clk) begin
            if (!rst_n)                  go_q <= 1'b0;
            else if (go_set && is_sel)   go_q <= 1'b1;
            else if (go_clr && is_sel)   go_q <= 1'b0;
        end

        // RESUME flag of hart h.
        always_ff @(posedge clk) begin
            if (!rst_n)                  res_q <= 1'b0;
            else if (res_set && is_sel)  res_q <= 1'b1;
            else if (res_clr && is_rid)  res_q <= 1'b0;
        end

        assign go[h]  = go_q;
        assign res[h] = res_q;
    end
endmodule

// File: rtl/dbg_mbox_status.sv
// Debugger-visible status: per-hart halted and resumeack, abstract busy and
// the command error field. Assumes mailbox strobes arrive already qualified
// (legal size, id in range).
module dbg_mbox_status
    import dbg_mbox_pkg::*;
#(
    parameter int NUM_HARTS = 16,
    parameter int HART_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HART_W-1:0]    sel,
    input  logic                 go_cmd,
    input  logic                 resume_cmd,
    input  logic                 halt_st,
    input  logic                 resume_st,
    input  logic                 exc_st,
    input  logic [HART_W-1:0]    st_id,
    input  logic [NUM_HARTS-1:0] go_flags,
    input  logic                 err_set,
    input  logic [2:0]           err_code,
    input  logic                 err_clr,
    output logic [NUM_HARTS-1:0] halted,
    output logic [NUM_HARTS-1:0] resumeack,
    output logic                 busy,
    output logic [2:0]           cmderr
);
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic halt_q, rack_q;
        logic hit;
        assign hit = (st_id == HART_W'(h));

        // Halted bit: set on HALTED, cleared on RESUMING.
        always_ff @(posedge clk) begin
            if (!rst_n)                 halt_q <= 1'b0;
            else if (halt_st && hit)    halt_q <= 1'b1;
            else if (resume_st && hit)  halt_q <= 1'b0;
        end

        // Resume acknowledge: set by the hart, cleared by a new resume request.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  rack_q <= 1'b0;
            else if (resume_st && hit)                   rack_q <= 1'b1;
            else if (resume_cmd && sel == HART_W'(h))    rack_q <= 1'b0;
        end

        assign halted[h]    = halt_q;
        assign resumeack[h] = rack_q;
    end

    // Busy: raised by a command, dropped when the selected hart parks idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (go_cmd)
            busy <= 1'b1;
        else if (halt_st && st_id == sel && !go_flags[st_id])
            busy <= 1'b0;
    end

    // Command error: first error sticks until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cmderr <= CE_NONE;
        else if (err_clr)           cmderr <= CE_NONE;
        else if (cmderr == CE_NONE) begin
            if (exc_st)             cmderr <= CE_EXCEPT;
            else if (err_set)       cmderr <= err_code;
        end
    end
endmodule

// File: rtl/dbg_hart_mailbox.sv
// Top of the debug hart handshake mailbox: decodes hart accesses, qualifies
// mailbox stores, muxes read data and registers a one-cycle response.
// Assumes one access per cycle and that the command generator drives sel_hart.
module dbg_hart_mailbox
    import dbg_mbox_pkg::*;
#(
    parameter int NUM_HARTS = 16,
    parameter int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [HART_W-1:0]    sel_hart,
    input  logic                 go_cmd,
    input  logic                 resume_cmd,
    input  logic [DATA_W-1:0]    abs_word0,
    input  logic [DATA_W-1:0]    abs_word1,
    input  logic                 err_set,
    input  logic [2:0]           err_code,
    input  logic                 err_clr,
    output logic [NUM_HARTS-1:0] halted,
    output logic [NUM_HARTS-1:0] resumeack,
    output logic                 busy,
    output logic [2:0]           cmderr
);
    localparam int FIDX_W = $clog2(FLAG_BYTES);

    region_e             region;
    logic                deny, bad_id, acc_err, wr_ok, id_ok;
    logic                halt_st, going_st, resume_st, exc_st;
    logic [HART_W-1:0]   st_id;
    logic [NUM_HARTS-1:0] go_flags, res_flags;
    logic [DATA_W-1:0]   rd_word;

    dbg_mbox_decode u_dec (
        .addr   (req_addr),
        .write  (req_write),
        .region (region),
        .deny   (deny)
    );

    // Mailbox store qualification.
    assign id_ok   = (req_wdata < DATA_W'(NUM_HARTS));
    assign st_id   = req_wdata[HART_W-1:0];
    assign bad_id  = req_write && (region == RG_HALTED || region == RG_RESUMING)
                     && (req_size != SZ_WORD || !id_ok);
    assign acc_err = deny || bad_id;
    assign wr_ok   = req_valid && req_write && !acc_err;

    assign halt_st   = wr_ok && region == RG_HALTED;
    assign going_st  = wr_ok && region == RG_GOING;
    assign resume_st = wr_ok && region == RG_RESUMING;
    assign exc_st    = wr_ok && region == RG_EXCEPT;

    dbg_mbox_flags #(.NUM_HARTS(NUM_HARTS), .HART_W(HART_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_hart),
        .go_set     (go_cmd),
        .go_clr     (going_st),
        .res_set    (resume_cmd),
        .res_clr    (resume_st),
        .res_clr_id (st_id),
        .go         (go_flags),
        .res        (res_flags)
    );

    dbg_mbox_status #(.NUM_HARTS(NUM_HARTS), .HART_W(HART_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_hart),
        .go_cmd     (go_cmd),
        .resume_cmd (resume_cmd),
        .halt_st    (halt_st),
        .resume_st  (resume_st),
        .exc_st     (exc_st),
        .st_id      (st_id),
        .go_flags   (go_flags),
        .err_set    (err_set),
        .err_code   (err_code),
        .err_clr    (err_clr),
        .halted     (halted),
        .resumeack  (resumeack),
        .busy       (busy),
        .cmderr     (cmderr)
    );

    // Read data mux: jump word, abstract buffer, or four flag bytes.
    always_comb begin
        logic [FIDX_W-1:0] idx;
        rd_word = '0;
        idx     = '0;
        case (region)
            RG_VECTOR: rd_word = VEC_WORD;
            RG_ABS:    rd_word = req_addr[2] ? abs_word1 : abs_word0;
            RG_FLAGS: begin
                for (int k = 0; k < 4; k++) begin
                    idx = {req_addr[FIDX_W-1:2], 2'(k)};
                    if (idx < FIDX_W'(NUM_HARTS)) begin
                        rd_word[8*k + FLAG_GO_BIT]  = go_flags[idx[HART_W-1:0]];
                        rd_word[8*k + FLAG_RES_BIT] = res_flags[idx[HART_W-1:0]];
                    end
                end
            end
            default:   rd_word = '0;
        endcase
    end

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && acc_err;
            rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/dbg_mbox_chk.sv
// Checker bound to the mailbox top; observes ports only.
module dbg_mbox_chk
    import dbg_mbox_pkg::*;
#(
    parameter int NUM_HARTS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 go_cmd,
    input logic                 err_clr,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [NUM_HARTS-1:0] halted,
    input logic [NUM_HARTS-1:0] resumeack,
    input logic                 busy,
    input logic [2:0]           cmderr
);
    assert_busy_rise_needs_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_cmd));

    assert_busy_fall_needs_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(req_valid && req_write
                              && req_addr[ADDR_W-1:2] == MB_HALTED[ADDR_W-1:2]));

    assert_ack_implies_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((resumeack & ~$past(resumeack) & halted) == '0));

    assert_cmderr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmderr != CE_NONE && !err_clr) |=> $stable(cmderr));

    assert_vector_write_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[ADDR_W-1:2] == VEC_ADDR[ADDR_W-1:2]) |=> rsp_err);

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err));
endmodule

bind dbg_hart_mailbox dbg_mbox_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .go_cmd    (go_cmd),
    .err_clr   (err_clr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .halted    (halted),
    .resumeack (resumeack),
    .busy      (busy),
    .cmderr    (cmderr)
);

// File: tb/tb_dbg_hart_mailbox.sv
// Bench: behavioural reference model, compared after every clock.
module tb_dbg_hart_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_size;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [3:0]  sel_hart;
    logic        go_cmd, resume_cmd;
    logic [31:0] abs_word0, abs_word1;
    logic        err_set, err_clr;
    logic [2:0]  err_code;
    logic [NH-1:0] halted, resumeack;
    logic        busy;
    logic [2:0]  cmderr;

    int vectors = 0;
    int miscompares = 0;

    // Reference model state
    bit m_go[NH], m_res[NH], m_halt[NH], m_rack[NH];
    bit m_busy;
    int m_err;
    bit e_valid, e_err;
    logic [31:0] e_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_hart_mailbox #(.NUM_HARTS(NH)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .sel_hart(sel_hart), .go_cmd(go_cmd), .resume_cmd(resume_cmd),
        .abs_word0(abs_word0), .abs_word1(abs_word1),
        .err_set(err_set), .err_code(err_code), .err_clr(err_clr),
        .halted(halted), .resumeack(resumeack), .busy(busy), .cmderr(cmderr)
    );

    function automatic logic [NH-1:0] pack(input bit v[NH]);
        logic [NH-1:0] r;
        for (int i = 0; i < NH; i++) r[i] = v[i];
        return r;
    endfunction

    // Compute the model's next state from current inputs, then advance a clock.
    task automatic cycle(input string tag);
        bit n_go[NH], n_res[NH], n_halt[NH], n_rack[NH];
        bit err, hs, gs, rs, xs;
        int a, id;
        logic [31:0] rd;
        n_go = m_go; n_res = m_res; n_halt = m_halt; n_rack = m_rack;
        a = int'(req_addr); id = int'(req_wdata);
        err = 1; rd = 0; hs = 0; gs = 0; rs = 0; xs = 0;
        if (req_write) begin
            if ((a >> 2) == ('h100 >> 2))      begin err = !(req_size == 2 && req_wdata < NH); hs = !err; end
            else if ((a >> 2) == ('h104 >> 2)) begin err = 0; gs = 1; end
            else if ((a >> 2) == ('h108 >> 2)) begin err = !(req_size == 2 && req_wdata < NH); rs = !err; end
            else if ((a >> 2) == ('h10C >> 2)) begin err = 0; xs = 1; end
        end else begin
            if ((a >> 2) == ('h300 >> 2))       begin err = 0; rd = 32'h0380006F; end
            else if (a >= 'h338 && a < 'h340)   begin err = 0; rd = (a & 4) ? abs_word1 : abs_word0; end
            else if (a >= 'h400 && a < 'h800) begin
                err = 0;
                for (int k = 0; k < 4; k++) begin
                    int b;
                    b = ((a - 'h400) & ~3) + k;
                    if (b < NH) rd[8*k +: 8] = {6'd0, m_res[b], m_go[b]};
                end
            end
        end
        if (!req_valid) begin err = 0; hs = 0; gs = 0; rs = 0; xs = 0; end
        e_valid = req_valid;
        e_err   = req_valid && err;
        e_rdata = (req_valid && !req_write && !err) ? rd : 0;
        if (gs) n_go[sel_hart] = 0;
        if (go_cmd) n_go[sel_hart] = 1;
        if (rs) begin n_res[id] = 0; n_halt[id] = 0; end
        if (resume_cmd) begin n_res[sel_hart] = 1; n_rack[sel_hart] = 0; end
        if (rs) n_rack[id] = 1;
        if (hs) n_halt[id] = 1;
        if (go_cmd) m_busy = 1;
        else if (hs && id == int'(sel_hart) && !m_go[id]) m_busy = 0;
        if (err_clr) m_err = 0;
        else if (m_err == 0) begin
            if (xs) m_err = 3;
            else if (err_set) m_err = int'(err_code);
        end
        m_go = n_go; m_res = n_res; m_halt = n_halt; m_rack = n_rack;
        @(posedge clk);
        @(negedge clk);
        vectors++;
        if (halted !== pack(m_halt) || resumeack !== pack(m_rack) || busy !== m_busy
            || cmderr !== 3'(m_err) || rsp_valid !== e_valid || rsp_err !== e_err
            || rsp_rdata !== e_rdata) begin
            miscompares++;
            $display("FAIL %s: actual halt=%h rack=%h busy=%b err=%0d v=%b e=%b d=%h expected halt=%h rack=%h busy=%b err=%0d v=%b e=%b d=%h",
                     tag, halted, resumeack, busy, cmderr, rsp_valid, rsp_err, rsp_rdata,
                     pack(m_halt), pack(m_rack), m_busy, m_err, e_valid, e_err, e_rdata);
        end
        req_valid = 0; req_write = 0; go_cmd = 0; resume_cmd = 0;
        err_set = 0; err_clr = 0;
    endtask

    task automatic rd(input logic [11:0] ad, input string tag);
        req_valid = 1; req_write = 0; req_size = 2; req_addr = ad; req_wdata = 0;
        cycle(tag);
    endtask

    task automatic wr(input logic [11:0] ad, input logic [31:0] d, input logic [1:0] sz, input string tag);
        req_valid = 1; req_write = 1; req_size = sz; req_addr = ad; req_wdata = d;
        cycle(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog: actual run still active, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
        sel_hart = 0; go_cmd = 0; resume_cmd = 0; abs_word0 = 32'h00A02023; abs_word1 = 32'h00100073;
        err_set = 0; err_code = 0; err_clr = 0;
        m_busy = 0; m_err = 0;
        for (int i = 0; i < NH; i++) begin m_go[i] = 0; m_res[i] = 0; m_halt[i] = 0; m_rack[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cycle("R1 reset state");
        rd(12'h400, "R1 flags clear");
        rd(12'h300, "R8 jump word");
        rd(12'h338, "R8 abs word0");
        rd(12'h33C, "R8 abs word1");
        // Halt / go / resume sequence on hart 2
        sel_hart = 2;
        go_cmd = 1; cycle("R2 go command");
        rd(12'h402, "R7 GO visible lane 2");
        wr(12'h100, 2, 2, "R4 halted with GO pending keeps busy");
        wr(12'h104, 0, 0, "R3 going clears GO");
        rd(12'h400, "R3 GO cleared");
        wr(12'h100, 5, 2, "R4 other hart does not clear busy");
        wr(12'h100, 2, 2, "R4 selected hart parks, busy drops");
        resume_cmd = 1; cycle("R2 resume command");
        rd(12'h400, "R2 RESUME bit");
        wr(12'h108, 2, 2, "R5 resuming store");
        rd(12'h400, "R5 RESUME cleared");
        resume_cmd = 1; cycle("R2 resumeack cleared by new resume");
        wr(12'h108, 2, 2, "R5 second ack");
        // Top hart lane and zero fill
        sel_hart = 15;
        go_cmd = 1; cycle("R2 go hart 15");
        rd(12'h40C, "R7 top lane");
        rd(12'h410, "R7 beyond last hart");
        rd(12'h7FC, "R7 end of region");
        // Exception handling
        wr(12'h10C, 0, 2, "R6 exception from none");
        wr(12'h10C, 0, 2, "R6 exception again");
        err_clr = 1; cycle("R11 clear");
        err_set = 1; err_code = 1; cycle("R11 generator error");
        wr(12'h10C, 0, 2, "R6 exception keeps existing error");
        err_set = 1; err_code = 4; cycle("R11 second error ignored");
        err_clr = 1; err_set = 1; err_code = 2; cycle("R11 clear wins");
        err_set = 1; err_code = 2; req_valid = 1; req_write = 1; req_size = 2;
        req_addr = 12'h10C; req_wdata = 0; cycle("R11 exception beats err_set");
        err_clr = 1; cycle("R11 clear again");
        // Refused accesses
        rd(12'h100, "R9 mailbox read");
        wr(12'h300, 32'hFFFF_FFFF, 2, "R9 jump word write");
        wr(12'h404, 32'h0303_0303, 2, "R9 flag write");
        rd(12'h900, "R9 unmapped");
        rd(12'h050, "R9 below window");
        wr(12'h100, 3, 0, "R9 halted byte store");
        wr(12'h100, 20, 2, "R9 halted id out of range");
        wr(12'h108, 15, 1, "R9 resuming half store");
        rd(12'h40C, "R9 flags unchanged");
        cycle("R10 idle no response");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule